// File: doc/BRIEF.md
# Frame-Protected Operand Stack

This block is the operand stack of a stack-machine processor, and it also keeps the frames of function calls. A synchronous command port takes an operation code, a data word and an index on every clock. Five operations work on the stored values. Push and pop work at the top of the stack. Frame read and frame write address an entry by its position from the base of the current frame. Call opens a new frame, and return closes it.

On a call, the caller names how many of its top values are arguments. The frame base, which is also the underflow floor, then moves directly under those values, so argument 0 is frame index 0. Everything below the floor belongs to the caller, and the callee cannot pop it, read it or overwrite it. The call can also reserve local slots after the last argument. These slots are zeroed one entry per clock while a busy flag is high. On a return, the stack is cut back to the frame base, the single result is written there, and the caller's floor is restored from a small internal stack of frame records.

Popped values and frame-read values come out on separate registered outputs. The outcome of each command is reported on two registered outputs, one for status and one for the error cause, in the cycle after the command.

Top module: `frame_stack`

## Requirements
- R1: PUSH (op 1) stores cmd_data on top of the stack. POP (op 2) removes the top entry and shows it on pop_data after the clock edge, in last-in first-out order. An accepted command reports status 1 (done) with error 0 (none).
- R2: A PUSH while DEPTH entries are stored is refused. It reports status 2 (refused) with error 2 (overflow), and the stored entries are unchanged.
- R3: A POP when the top of the stack equals the current floor is refused with error 1 (underflow). pop_data keeps its value, and the protected entries stay intact.
- R4: READ (op 3) with index i shows the entry at frame base + i on read_data one cycle later. pop_data is not affected by reads.
- R5: A READ or SET whose position frame base + i is at or above the top of the stack reports error 3 (index). A refused READ drives read_data to zero.
- R6: CALL (op 5) takes cmd_data as the argument count n. It moves the floor to top − n, so argument 0 is read at frame index 0. A CALL with n larger than the number of entries in the current frame is refused with underflow.
- R7: The CALL index gives the number of local slots m. These slots are appended after the arguments at frame indices n..n+m−1 and are written to zero one per cycle. busy stays high for exactly m cycles after the CALL.
- R8: Any non-zero op that arrives while busy is high is refused with status 3 (busy) and has no effect on the stack.
- R9: RET (op 6) writes cmd_data at the frame base, sets the top of the stack to base + 1 and restores the caller's floor. A RET with no open frame is refused with underflow.
- R10: A CALL when FRAMES frames are already open is refused with overflow. A CALL whose locals would take the stack beyond DEPTH entries is also refused with overflow.
- R11: SET (op 4) writes cmd_data at frame base + cmd_idx, inside the current frame.
- R12: After reset, status and error are 0, busy is low, pop_data and read_data are zero, and the stack is empty, so a POP underflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Operation: 0 none, 1 push, 2 pop, 3 read, 4 set, 5 call, 6 return |
| cmd_data | input | DATA_W | Push/set/return value, or argument count for call |
| cmd_idx | input | IDX_W | Frame index for read/set, local count for call |
| pop_data | output | DATA_W | Value removed by the last accepted pop |
| read_data | output | DATA_W | Value of the last frame read (zero on index error) |
| status | output | 2 | 0 none, 1 done, 2 refused, 3 refused busy |
| error | output | 2 | 0 none, 1 underflow, 2 overflow, 3 index |
| busy | output | 1 | High while local slots are being cleared |

## Verification
A top-of-stack pointer or floor that is off by one shows at the ports within a cycle or two. The fault appears as a frame read that returns a neighbouring value, or as an index error on what should be the last valid index. A corrupted floor also shows up as a pop that wrongly succeeds into the caller's values or wrongly underflows. A clear sequencer that stops early leaves stale data in a local slot, and one that stops late gives a busy pulse of the wrong length. Both are visible as soon as the locals are read back after busy falls. A frame-record fault is seen on the first read after a return, which exposes the restored floor.

// File: rtl/fstk_pkg.sv
package fstk_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_READ = 3'd3,
    OP_SET  = 3'd4,
    OP_CALL = 3'd5,
    OP_RET  = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    ST_NONE = 2'd0,
    ST_OK   = 2'd1,
    ST_ERR  = 2'd2,
    ST_BUSY = 2'd3
  } st_e;

  typedef enum logic [1:0] {
    ER_NONE  = 2'd0,
    ER_UNDER = 2'd1,
    ER_OVER  = 2'd2,
    ER_INDEX = 2'd3
  } er_e;
endpackage

// File: rtl/fstk_ram.sv
// One write port and two synchronous read ports, each read port with its
// own output register, so the array maps onto block or distributed RAM.
module fstk_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ra_en,
  input  logic [AW-1:0]     ra_addr,
  output logic [DATA_W-1:0] ra_q,
  input  logic              rb_en,
  input  logic              rb_zero,
  input  logic [AW-1:0]     rb_addr,
  output logic [DATA_W-1:0] rb_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        ra_q <= '0;
    else if (ra_en) ra_q <= mem[ra_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)          rb_q <= '0;
    else if (rb_zero) rb_q <= '0;
    else if (rb_en)   rb_q <= mem[rb_addr];
  end
endmodule

// File: rtl/fstk_frames.sv
// Small LIFO of saved floors, one record per open call frame.
module fstk_frames #(
  parameter int PTR_W  = 5,
  parameter int FRAMES = 4,
  localparam int CW    = $clog2(FRAMES + 1),
  localparam int RW    = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [PTR_W-1:0] push_val,
  input  logic             pop,
  output logic [PTR_W-1:0] top_val,
  output logic             full,
  output logic             empty
);
  logic [PTR_W-1:0] recs [FRAMES];
  logic [CW-1:0]    cnt_q;
  logic [RW-1:0]    wr_slot, top_slot;

  assign wr_slot  = RW'(cnt_q);
  assign top_slot = RW'(cnt_q - 1'b1);
  assign full     = (cnt_q == CW'(FRAMES));
  assign empty    = (cnt_q == '0);
  assign top_val  = recs[top_slot];

  always_ff @(posedge clk) begin
    if (push && !full) recs[wr_slot] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (push && !full)   cnt_q <= cnt_q + 1'b1;
    else if (pop && !empty)   cnt_q <= cnt_q - 1'b1;
  end

  // R10: the controller never opens a frame when every record is taken
  p_frame_room_r10: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R9: the controller never closes a frame that does not exist
  p_frame_exists_r9: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/frame_stack.sv
module frame_stack #(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 16,
  parameter int FRAMES  = 4,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [IDX_W-1:0]  cmd_idx,
  output logic [DATA_W-1:0] pop_data,
  output logic [DATA_W-1:0] read_data,
  output logic [1:0]        status,
  output logic [1:0]        error,
  output logic              busy
);
  import fstk_pkg::*;

  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int EW    = PTR_W + 1;

  logic [PTR_W-1:0] sp_q, sp_d, floor_q, floor_d;
  logic [IDX_W-1:0] clr_q, clr_d;
  logic [1:0]       st_q, st_d, er_q, er_d;

  logic              we, ra_en, rb_en, rb_zero;
  logic [IDX_W-1:0]  waddr, ra_addr, rb_addr;
  logic [DATA_W-1:0] wdata;
  logic              fr_push, fr_pop, fr_full, fr_empty;
  logic [PTR_W-1:0]  fr_top;

  logic [EW-1:0]    ix_abs;
  logic             ix_ok;
  logic [PTR_W-1:0] frame_cnt, new_floor;
  logic             args_bad, room_bad;

  assign busy      = (clr_q != '0);
  assign ix_abs    = EW'(floor_q) + EW'(cmd_idx);
  assign ix_ok     = ix_abs < EW'(sp_q);
  assign frame_cnt = sp_q - floor_q;
  assign args_bad  = cmd_data > DATA_W'(frame_cnt);
  assign new_floor = sp_q - PTR_W'(cmd_data);
  assign room_bad  = (EW'(sp_q) + EW'(cmd_idx) > EW'(DEPTH)) ||
                     (new_floor == PTR_W'(DEPTH));

  always_comb begin
    we      = 1'b0;
    waddr   = IDX_W'(sp_q);
    wdata   = '0;
    ra_en   = 1'b0;
    ra_addr = IDX_W'(sp_q - 1'b1);
    rb_en   = 1'b0;
    rb_zero = 1'b0;
    rb_addr = IDX_W'(ix_abs);
    sp_d    = sp_q;
    floor_d = floor_q;
    clr_d   = clr_q;
    st_d    = ST_NONE;
    er_d    = ER_NONE;
    fr_push = 1'b0;
    fr_pop  = 1'b0;
    if (busy) begin
      // zero one local slot per cycle, refuse whatever arrives
      we    = 1'b1;
      sp_d  = sp_q + 1'b1;
      clr_d = clr_q - 1'b1;
      if (cmd_op != '0) st_d = ST_BUSY;
    end else begin
      case (op_e'(cmd_op))
        OP_PUSH: begin
          if (sp_q == PTR_W'(DEPTH)) begin
            st_d = ST_ERR; er_d = ER_OVER;
          end else begin
            we = 1'b1; wdata = cmd_data; sp_d = sp_q + 1'b1; st_d = ST_OK;
          end
        end
        OP_POP: begin
          if (sp_q == floor_q) begin
            st_d = ST_ERR; er_d = ER_UNDER;
          end else begin
            ra_en = 1'b1; sp_d = sp_q - 1'b1; st_d = ST_OK;
          end
        end
        OP_READ: begin
          if (!ix_ok) begin
            rb_zero = 1'b1; st_d = ST_ERR; er_d = ER_INDEX;
          end else begin
            rb_en = 1'b1; st_d = ST_OK;
          end
        end
        OP_SET: begin
          if (!ix_ok) begin
            st_d = ST_ERR; er_d = ER_INDEX;
          end else begin
            we = 1'b1; waddr = IDX_W'(ix_abs); wdata = cmd_data; st_d = ST_OK;
          end
        end
        OP_CALL: begin
          if (args_bad) begin
            st_d = ST_ERR; er_d = ER_UNDER;
          end else if (fr_full || room_bad) begin
            st_d = ST_ERR; er_d = ER_OVER;
          end else begin
            fr_push = 1'b1;
            floor_d = new_floor;
            clr_d   = cmd_idx;
            st_d    = ST_OK;
          end
        end
        OP_RET: begin
          if (fr_empty) begin
            st_d = ST_ERR; er_d = ER_UNDER;
          end else begin
            we      = 1'b1;
            waddr   = IDX_W'(floor_q);
            wdata   = cmd_data;
            sp_d    = floor_q + 1'b1;
            floor_d = fr_top;
            fr_pop  = 1'b1;
            st_d    = ST_OK;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q    <= '0;
      floor_q <= '0;
      clr_q   <= '0;
      st_q    <= ST_NONE;
      er_q    <= ER_NONE;
    end else begin
      sp_q    <= sp_d;
      floor_q <= floor_d;
      clr_q   <= clr_d;
      st_q    <= st_d;
      er_q    <= er_d;
    end
  end

  assign status = st_q;
  assign error  = er_q;

  fstk_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .ra_en(ra_en), .ra_addr(ra_addr), .ra_q(pop_data),
    .rb_en(rb_en), .rb_zero(rb_zero), .rb_addr(rb_addr), .rb_q(read_data)
  );

  fstk_frames #(.PTR_W(PTR_W), .FRAMES(FRAMES)) u_frames (
    .clk(clk), .rst(rst), .push(fr_push), .push_val(floor_q), .pop(fr_pop),
    .top_val(fr_top), .full(fr_full), .empty(fr_empty)
  );

  // R6: the protected floor never rises above the top of the stack
  p_floor_below_top_r6: assert property (@(posedge clk) disable iff (rst)
    floor_q <= sp_q);
  // R8: a command during the clear is refused as busy
  p_busy_refuse_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_op != 3'd0) |=> (status == ST_BUSY));
  // R3: pop at the floor underflows and leaves the pointer alone
  p_pop_at_floor_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_op == OP_POP && sp_q == floor_q)
      |=> (error == ER_UNDER && $stable(sp_q)));
  // R2: push into a full stack overflows
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_op == OP_PUSH && sp_q == PTR_W'(DEPTH))
      |=> (error == ER_OVER && $stable(sp_q)));
  // R5: an out-of-frame read returns zero
  p_bad_index_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_op == OP_READ && !ix_ok) |=> (read_data == '0));
  // R9: return leaves exactly the result above the old base
  p_ret_cut_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmd_op == OP_RET && !fr_empty)
      |=> (sp_q == $past(floor_q) + 1'b1));
endmodule

// File: tb/tb_frame_stack.sv
`timescale 1ns/1ps
module tb_frame_stack;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd_op = '0;
  logic [15:0] cmd_data = '0;
  logic [3:0]  cmd_idx = '0;
  logic [15:0] pop_data, read_data;
  logic [1:0]  status, error;
  logic        busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  frame_stack #(.DATA_W(16), .DEPTH(16), .FRAMES(4)) dut (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_idx(cmd_idx), .pop_data(pop_data), .read_data(read_data),
    .status(status), .error(error), .busy(busy)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] data;
    logic [3:0]  idx;
    logic [1:0]  st;
    logic [1:0]  er;
    logic [1:0]  sel;   // 0 no value, 1 pop_data, 2 read_data
    logic [15:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 16'd10, 4'd0, 2'd1, 2'd0, 2'd0, 16'd0,  4'd1},  // R1 push
    '{3'd1, 16'd20, 4'd0, 2'd1, 2'd0, 2'd0, 16'd0,  4'd1},  // R1 push
    '{3'd1, 16'd30, 4'd0, 2'd1, 2'd0, 2'd0, 16'd0,  4'd1},  // R1 push
    '{3'd3, 16'd0,  4'd0, 2'd1, 2'd0, 2'd2, 16'd10, 4'd4},  // R4 read base
    '{3'd3, 16'd0,  4'd2, 2'd1, 2'd0, 2'd2, 16'd30, 4'd4},  // R4 read top
    '{3'd3, 16'd0,  4'd3, 2'd2, 2'd3, 2'd2, 16'd0,  4'd5},  // R5 past top
    '{3'd2, 16'd0,  4'd0, 2'd1, 2'd0, 2'd1, 16'd30, 4'd1},  // R1 pop
    '{3'd4, 16'd99, 4'd1, 2'd1, 2'd0, 2'd0, 16'd0,  4'd11}, // R11 set
    '{3'd3, 16'd0,  4'd1, 2'd1, 2'd0, 2'd2, 16'd99, 4'd11}, // R11 readback
    '{3'd0, 16'd0,  4'd0, 2'd0, 2'd0, 2'd1, 16'd30, 4'd4},  // R4 pop_data kept
    '{3'd2, 16'd0,  4'd0, 2'd1, 2'd0, 2'd1, 16'd99, 4'd1},  // R1 pop
    '{3'd2, 16'd0,  4'd0, 2'd1, 2'd0, 2'd1, 16'd10, 4'd1},  // R1 pop
    '{3'd2, 16'd0,  4'd0, 2'd2, 2'd1, 2'd1, 16'd10, 4'd3},  // R3 empty pop
    '{3'd4, 16'd5,  4'd0, 2'd2, 2'd3, 2'd0, 16'd0,  4'd5}   // R5 set past top
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [15:0] d, input logic [3:0] i);
    @(negedge clk);
    cmd_op = op; cmd_data = d; cmd_idx = i;
    @(posedge clk);
    #1;
    cmd_op = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmd_op = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_sim();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    int bc;
    do_reset();
    #1;
    // R12 reset state
    chk("R12 status", status, 0);
    chk("R12 error", error, 0);
    chk("R12 busy", busy, 0);
    chk("R12 pop_data", pop_data, 0);
    chk("R12 read_data", read_data, 0);
    cmd(3'd2, 0, 0);
    chk("R12 empty pop", error, 1);

    // table walk
    do_reset();
    for (int k = 0; k < NV; k++) begin
      cmd(VEC[k].op, VEC[k].data, VEC[k].idx);
      chk($sformatf("R%0d status row %0d", VEC[k].req, k), status, VEC[k].st);
      chk($sformatf("R%0d error row %0d", VEC[k].req, k), error, VEC[k].er);
      if (VEC[k].sel == 2'd1)
        chk($sformatf("R%0d pop_data row %0d", VEC[k].req, k), pop_data, VEC[k].val);
      else if (VEC[k].sel == 2'd2)
        chk($sformatf("R%0d read_data row %0d", VEC[k].req, k), read_data, VEC[k].val);
    end

    // R2 fill to DEPTH, then overflow
    do_reset();
    for (int k = 0; k < 16; k++) cmd(3'd1, 16'(k + 1), 0);
    chk("R2 last fill ok", status, 1);
    cmd(3'd1, 16'd500, 0);
    chk("R2 overflow status", status, 2);
    chk("R2 overflow error", error, 2);
    cmd(3'd2, 0, 0);
    chk("R2 top unchanged", pop_data, 16);

    // R6 R7 R8 call with 2 args and 3 locals over stale memory
    do_reset();
    cmd(3'd1, 16'd5, 0);
    cmd(3'd1, 16'd6, 0);
    cmd(3'd1, 16'd7, 0);
    cmd(3'd5, 16'd2, 4'd3);
    chk("R6 call ok", status, 1);
    bc = busy ? 1 : 0;
    cmd(3'd1, 16'd77, 0);
    chk("R8 busy refuse", status, 3);
    chk("R8 busy no error", error, 0);
    if (busy) bc++;
    for (int n = 0; n < 20 && busy; n++) begin
      @(posedge clk); #1;
      if (busy) bc++;
    end
    chk("R7 busy length", bc, 3);
    cmd(3'd3, 0, 4'd0);
    chk("R6 arg0 at index 0", read_data, 6);
    cmd(3'd3, 0, 4'd1);
    chk("R6 arg1", read_data, 7);
    cmd(3'd3, 0, 4'd2);
    chk("R7 local0 zero", read_data, 0);
    cmd(3'd3, 0, 4'd4);
    chk("R7 local2 zero", read_data, 0);
    cmd(3'd3, 0, 4'd5);
    chk("R8 refused push absent", error, 3);
    for (int k = 0; k < 5; k++) cmd(3'd2, 0, 0);
    chk("R6 last frame pop", pop_data, 6);
    cmd(3'd2, 0, 0);
    chk("R3 floor protects caller", error, 1);
    chk("R3 pop_data kept", pop_data, 6);
    cmd(3'd6, 16'd42, 0);
    chk("R9 return ok", status, 1);
    cmd(3'd3, 0, 4'd0);
    chk("R9 caller floor restored", read_data, 5);
    cmd(3'd3, 0, 4'd1);
    chk("R9 result at base", read_data, 42);
    cmd(3'd3, 0, 4'd2);
    chk("R9 stack cut", error, 3);
    cmd(3'd6, 16'd1, 0);
    chk("R9 top-level return", error, 1);
    cmd(3'd5, 16'd3, 4'd0);
    chk("R6 too many args", error, 1);
    cmd(3'd3, 0, 4'd1);
    chk("R6 no change after bad call", read_data, 42);

    // R10 frame records full
    do_reset();
    cmd(3'd1, 16'd1, 0);
    for (int k = 0; k < 4; k++) cmd(3'd5, 0, 0);
    chk("R10 fourth call ok", status, 1);
    cmd(3'd5, 0, 0);
    chk("R10 frames full", error, 2);
    cmd(3'd6, 16'd9, 0);
    chk("R10 return after refusal", status, 1);
    cmd(3'd3, 0, 4'd0);
    chk("R9 nested result", read_data, 9);

    // R10 locals beyond DEPTH
    do_reset();
    cmd(3'd1, 16'd1, 0);
    cmd(3'd1, 16'd2, 0);
    cmd(3'd5, 0, 4'd15);
    chk("R10 locals overflow", error, 2);
    chk("R10 no clear started", busy, 0);

    done = 1'b1;
    finish_sim();
  end
endmodule